// File: doc/BRIEF.md
# Shared Host Interrupt Line for a Keyboard-Controller-Style Message Port

This block drives one level-sensitive interrupt line toward the host processor from two independent causes. The first cause is new data in the outbound data register, which the transfer engine reports as a one-cycle event. The second cause is an attention request from the management controller, which tells host software that a message is waiting for it. Each cause has its own latched pending flag, and the line is high while either flag is set.

The two flags are released by different host actions. A host read of the data port clears the data-ready flag. A host read of the status port clears the attention flag. A flag can only latch while the interrupt is wired in (a strap input) and the global enable is on. Dropping the enable stops new flags from latching but leaves pending flags as they are. The attention status bit that the host sees in the status register is kept here too. It follows set and clear requests whether or not an interrupt is in use.

All state is registered. The line output comes from a flop that samples the OR of the two flags, so it changes one clock after the flags change and never glitches.

Top module: `kcs_irq_ctrl`

## Requirements
- R1: After reset, `host_irq` and `status_atn` are both 0.
- R2: On a clock with `obf_set` high, the data-ready flag becomes set only if `irq_used` and `irq_enable` are both 1. Otherwise it keeps its value.
- R3: A clock with `host_data_rd` high and no qualifying `obf_set` clears the data-ready flag. The line stays high if the attention flag is still set.
- R4: A clock with `host_status_rd` high and no qualifying attention set clears the attention flag. The line stays high if the data-ready flag is still set.
- R5: `status_atn` becomes 1 on the clock after `atn_set_req` and 0 on the clock after `atn_clr_req`. Clear wins when both are requested together. It does not depend on `irq_used`, `irq_enable` or `atn_irq_req`.
- R6: The attention flag becomes set only on a clock with `atn_set_req`, `atn_irq_req`, `irq_used` and `irq_enable` all 1 and `atn_clr_req` 0.
- R7: `atn_clr_req` clears the attention flag. The line stays high if the data-ready flag is set.
- R8: `host_irq` equals the OR of the two flags as they stood one clock earlier. This is two clocks after the event that changed a flag.
- R9: Changing `irq_enable` to 0 does not clear a flag that is already set.
- R10: When a qualifying set of a flag and a host read that clears that flag fall in the same clock, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_used | input | 1 | Strap: interrupt line is wired in |
| irq_enable | input | 1 | Global interrupt enable |
| obf_set | input | 1 | One-cycle event: outbound data became valid |
| atn_set_req | input | 1 | Controller requests attention |
| atn_irq_req | input | 1 | Attention request should also interrupt |
| atn_clr_req | input | 1 | Controller withdraws attention |
| host_data_rd | input | 1 | Host read strobe on the data port |
| host_status_rd | input | 1 | Host read strobe on the status port |
| host_irq | output | 1 | Level interrupt line to the host |
| status_atn | output | 1 | Attention bit for the status register |

## Verification
Directed sequences raise both sources together and then release them in each of the two orders. This shows whether a read of one port releases the line while the other source is still pending. Further sequences latch events with the strap or the enable off, drop the enable while a flag is set, and put sets and clearing reads in the same clock. These separate gating errors, priority errors and errors where disabling also clears a flag. Long random runs then toggle every input with different densities. They catch interactions that the directed cases miss, for example a status read that arrives just as an attention request without an interrupt comes in.

// File: rtl/kcs_irq_pkg.sv
package kcs_irq_pkg;

    localparam int SRC_CNT = 2;
    localparam int SRC_OBF = 0;
    localparam int SRC_ATN = 1;

    typedef struct packed {
        logic flag;
    } src_state_t;

    typedef struct packed {
        logic bit_val;
    } atn_state_t;

    typedef struct packed {
        logic line;
    } merge_state_t;

endpackage

// File: rtl/kcs_irq_src.sv
module kcs_irq_src
    import kcs_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic gate,
    input  logic clr_evt,
    output logic flag_o
);
    src_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_evt && gate) begin
            st_d.flag = 1'b1;
        end else if (clr_evt) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R2
    src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !(set_evt && gate)) |=> !flag_o);

    // R3
    src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !(set_evt && gate)) |=> !flag_o);

    // R10
    src_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && gate && clr_evt) |=> flag_o);

    // R9
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_evt) |=> flag_o);
endmodule

// File: rtl/kcs_irq_atn_status.sv
module kcs_irq_atn_status
    import kcs_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic bit_o
);
    atn_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req)      st_d.bit_val = 1'b0;
        else if (set_req) st_d.bit_val = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.bit_val;

    // R5
    atn_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !bit_o);

    // R5
    atn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr_req) |=> bit_o);
endmodule

// File: rtl/kcs_irq_merge.sv
module kcs_irq_merge
    import kcs_irq_pkg::*;
#(
    parameter int N = SRC_CNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_flags,
    output logic         line_o
);
    merge_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.line = |src_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = st_q.line;

    // R8
    line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_flags) |=> line_o);

    // R8
    line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_flags == '0) |=> !line_o);
endmodule

// File: rtl/kcs_irq_ctrl.sv
module kcs_irq_ctrl
    import kcs_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_used,
    input  logic irq_enable,
    input  logic obf_set,
    input  logic atn_set_req,
    input  logic atn_irq_req,
    input  logic atn_clr_req,
    input  logic host_data_rd,
    input  logic host_status_rd,
    output logic host_irq,
    output logic status_atn
);
    logic               gate;
    logic [SRC_CNT-1:0] src_set;
    logic [SRC_CNT-1:0] src_clr;
    logic [SRC_CNT-1:0] src_flag;

    always_comb begin
        gate             = irq_used && irq_enable;
        src_set          = '0;
        src_clr          = '0;
        src_set[SRC_OBF] = obf_set;
        src_clr[SRC_OBF] = host_data_rd;
        src_set[SRC_ATN] = atn_set_req && atn_irq_req && !atn_clr_req;
        src_clr[SRC_ATN] = atn_clr_req || host_status_rd;
    end

    for (genvar i = 0; i < SRC_CNT; i++) begin : g_src
        kcs_irq_src u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (src_set[i]),
            .gate    (gate),
            .clr_evt (src_clr[i]),
            .flag_o  (src_flag[i])
        );
    end

    kcs_irq_atn_status u_atn (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (atn_set_req),
        .clr_req (atn_clr_req),
        .bit_o   (status_atn)
    );

    kcs_irq_merge #(.N(SRC_CNT)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_flags (src_flag),
        .line_o    (host_irq)
    );

    // R6
    atn_flag_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_flag[SRC_ATN]) |->
            $past(atn_set_req && atn_irq_req && irq_used && irq_enable && !atn_clr_req));

    // R2
    obf_flag_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_flag[SRC_OBF]) |-> $past(obf_set && irq_used && irq_enable));

    // R7
    atn_clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        atn_clr_req |=> !src_flag[SRC_ATN]);
endmodule

// File: tb/tb_kcs_irq_ctrl.sv
module tb_kcs_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic irq_used, irq_enable, obf_set, atn_set_req, atn_irq_req, atn_clr_req;
    logic host_data_rd, host_status_rd;
    logic host_irq, status_atn;

    int n_chk = 0;
    int n_fail = 0;

    logic m_obf, m_atn, m_stat, m_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    kcs_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_used(irq_used), .irq_enable(irq_enable),
        .obf_set(obf_set), .atn_set_req(atn_set_req), .atn_irq_req(atn_irq_req),
        .atn_clr_req(atn_clr_req), .host_data_rd(host_data_rd),
        .host_status_rd(host_status_rd), .host_irq(host_irq), .status_atn(status_atn)
    );

    function automatic logic nxt_obf(logic cur, logic g, logic s, logic rd);
        if (s && g) return 1'b1;
        if (rd)     return 1'b0;
        return cur;
    endfunction

    function automatic logic nxt_atn(logic cur, logic g, logic s, logic irq, logic clr, logic rd);
        if (s && irq && g && !clr) return 1'b1;
        if (clr || rd)             return 1'b0;
        return cur;
    endfunction

    function automatic logic nxt_stat(logic cur, logic s, logic clr);
        if (clr) return 1'b0;
        if (s)   return 1'b1;
        return cur;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_ins();
        obf_set = 0; atn_set_req = 0; atn_irq_req = 0; atn_clr_req = 0;
        host_data_rd = 0; host_status_rd = 0;
    endtask

    // inputs set at negedge before call; advance one clock and compare
    task automatic step(input string tag);
        logic g;
        @(posedge clk);
        g = irq_used && irq_enable;
        m_line = m_obf || m_atn;
        m_obf  = nxt_obf(m_obf, g, obf_set, host_data_rd);
        m_atn  = nxt_atn(m_atn, g, atn_set_req, atn_irq_req, atn_clr_req, host_status_rd);
        m_stat = nxt_stat(m_stat, atn_set_req, atn_clr_req);
        @(negedge clk);
        check(host_irq, m_line, {tag, " line (R8)"});
        check(status_atn, m_stat, {tag, " status_atn (R5)"});
        clear_ins();
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; irq_used = 1; irq_enable = 1; clear_ins();
        m_obf = 0; m_atn = 0; m_stat = 0; m_line = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(host_irq, 1'b0, "R1 reset host_irq");
        check(status_atn, 1'b0, "R1 reset status_atn");

        // R2: strap off
        irq_used = 0; obf_set = 1; step("R2 strap off"); idle(2, "R2 strap off");
        check(host_irq, 1'b0, "R2 no line with strap off");
        // R2: enable off
        irq_used = 1; irq_enable = 0; obf_set = 1; step("R2 enable off"); idle(2, "R2 enable off");
        check(host_irq, 1'b0, "R2 no line with enable off");
        irq_enable = 1; obf_set = 1; step("R2 latch"); idle(1, "R2 latch");
        check(host_irq, 1'b1, "R2 line after qualified obf_set");

        // R3: attention pending keeps line up after data read
        atn_set_req = 1; atn_irq_req = 1; step("R3 atn"); idle(1, "R3");
        host_data_rd = 1; step("R3 data read"); idle(2, "R3");
        check(host_irq, 1'b1, "R3 line held by attention");
        host_status_rd = 1; step("R4 status read"); idle(2, "R4");
        check(host_irq, 1'b0, "R4 line low after both cleared");

        // R4: other order
        obf_set = 1; atn_set_req = 1; atn_irq_req = 1; step("R4 both"); idle(1, "R4");
        host_status_rd = 1; step("R4 status read"); idle(2, "R4");
        check(host_irq, 1'b1, "R4 line held by data-ready");
        host_data_rd = 1; step("R3 data read"); idle(2, "R3");
        check(host_irq, 1'b0, "R3 line low after data read");

        // R7
        atn_set_req = 1; atn_irq_req = 1; step("R7 set"); idle(1, "R7");
        atn_clr_req = 1; step("R7 clr"); idle(2, "R7");
        check(host_irq, 1'b0, "R7 line low after attention withdraw");
        check(status_atn, 1'b0, "R7 status cleared");

        // R9
        obf_set = 1; step("R9 set"); irq_enable = 0; idle(3, "R9");
        check(host_irq, 1'b1, "R9 flag kept after enable drop");
        host_data_rd = 1; step("R9 read"); irq_enable = 1; idle(2, "R9");

        // R10
        obf_set = 1; host_data_rd = 1; step("R10 same cycle"); idle(2, "R10");
        check(host_irq, 1'b1, "R10 obf set wins over data read");
        host_data_rd = 1; step("R10"); idle(1, "R10");
        atn_set_req = 1; atn_irq_req = 1; host_status_rd = 1; step("R10 atn"); idle(2, "R10");
        check(host_irq, 1'b1, "R10 attention set wins over status read");
        atn_clr_req = 1; step("R10"); idle(2, "R10");

        // R5 / R6
        atn_set_req = 1; step("R5 set no irq"); idle(2, "R6");
        check(status_atn, 1'b1, "R5 status set without interrupt");
        check(host_irq, 1'b0, "R6 no line without irq request");
        atn_set_req = 1; atn_irq_req = 1; atn_clr_req = 1; step("R5 both"); idle(2, "R6");
        check(status_atn, 1'b0, "R5 clear wins");
        check(host_irq, 1'b0, "R6 no latch when clear requested");

        // random phase
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            irq_used       = ($urandom % 16) != 0;
            irq_enable     = ($urandom % 8) != 0;
            obf_set        = ($urandom % 6) == 0;
            atn_set_req    = ($urandom % 7) == 0;
            atn_irq_req    = ($urandom % 2) == 0;
            atn_clr_req    = ($urandom % 11) == 0;
            host_data_rd   = ($urandom % 5) == 0;
            host_status_rd = ($urandom % 5) == 0;
            step("R8 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule